// File: doc/BRIEF.md
# Shift-Add Eight-Point Forward DCT

This block turns eight signed fixed-point samples into the eight coefficients of a one-dimensional forward discrete cosine transform. It contains no multiplier. The samples first pass through a butterfly that forms mirror-pair sums and differences. The even coefficients come from a second butterfly on the sums. The odd coefficients come from weighted combinations of the four differences.

Every constant product is built from shifts and two-input adders. Each difference operand gets one small set of shared shift-add terms, and all four odd-path constants are assembled from that set. The block is meant as the row or column engine of a larger two-dimensional transform. It accepts one sample vector per clock and marks each result with a valid strobe.

A parameter selects the build. One build places a register after every adder level, for a latency of six clocks. The other is a single combinational datapath with one output register, for a latency of one clock.

Top module: `dct8_shiftadd`

## Requirements
- R1: Samples and coefficients are 20-bit two's-complement words with 7 fraction bits. Sample k sits at bits [20k+19:20k] of `in_samples`, and coefficient k sits at the same bits of `out_coefs`. With s_i = x_i + x_(7-i), P = s0+s3 and Q = s1+s2, coefficient 0 is 45·(P+Q) and coefficient 4 is 45·(P−Q), in units of 2^-14 before the final truncation.
- R2: With U = s0−s3 and V = s1−s2, coefficient 2 is 59·U + 24·V and coefficient 6 is 24·U − 59·V.
- R3: With d_i = x_i − x_(7−i) and weights A=63, C=53, D=36, F=12, coefficient 1 is A·d0+C·d1+D·d2+F·d3, coefficient 3 is C·d0−F·d1−A·d2−D·d3, coefficient 5 is D·d0−A·d1+F·d2+C·d3, and coefficient 7 is F·d0−D·d1+C·d2−A·d3.
- R4: All intermediate sums keep full width. Each coefficient is truncated once, at the output, by an arithmetic right shift of 7 (rounding toward minus infinity), and its low 20 bits are kept. A sample vector with only x0 = −1 LSB therefore gives −1 LSB on every coefficient.
- R5: With PIPELINED=1, `out_valid` and the matching coefficients appear exactly six clocks after the edge that takes in the vector with `in_valid` high.
- R6: With PIPELINED=0, `out_valid` and the matching coefficients appear one clock after the edge that takes in the vector.
- R7: A new vector can be taken in on every clock, and back-to-back vectors come out on consecutive clocks in the same order.
- R8: While `rst_n` is low, `out_valid` is low and `out_coefs` is all zero.
- R9: A vector presented with `in_valid` low yields no `out_valid`. While `out_valid` is low, `out_coefs` holds the last valid result.
- R10: An all-zero valid vector gives all-zero coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_samples` as a vector to transform |
| in_samples | input | 160 | Eight packed signed samples, sample 0 in the low bits |
| out_valid | output | 1 | Marks `out_coefs` as a fresh result |
| out_coefs | output | 160 | Eight packed signed coefficients, coefficient 0 in the low bits |

## Verification
The bench drives both builds with the same stream of vectors. The stream includes a one-clock gap, a constant vector that has energy only in coefficient 0, a ramp, an alternating pattern and mixed-sign data near full scale. A design that mixed up a sign in one odd row, or swapped B and E in the rotation, would put wrong values on those lanes for the ramp and mixed vectors. A single negative LSB on x0 targets the truncation rule: rounding toward zero, or truncating each partial product separately, would give 0 instead of −1. The gap and a reset in the middle of the stream test the valid pipeline. A design that sent the gap data through, or left stale valids in flight, would raise `out_valid` at the wrong clock.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
    parameter int LANES  = 8;
    parameter int DATA_W = 20;
    parameter int FRAC_W = 7;
    // headroom: largest odd weight sum is 164 (< 2^8) on a 21-bit difference
    parameter int GUARD_W = 12;
    parameter int ACC_W  = DATA_W + GUARD_W;
    parameter int BUS_W  = LANES * DATA_W;

    typedef logic signed [ACC_W-1:0] acc_t;
endpackage

// File: rtl/dct8_stage.sv
// One pipeline boundary. PIPE=1 registers data and valid; PIPE=0 is a wire.
// Data only loads with a valid beat, so the stage holds its last result.
module dct8_stage
    import dct8_pkg::*;
#(
    parameter int N    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  acc_t d_i [N],
    output logic vld_o,
    output acc_t d_o [N]
);
    generate
        if (PIPE) begin : g_reg
            typedef struct {
                logic vld;
                acc_t val [N];
            } stage_t;

            stage_t st_d, st_q;

            always_comb begin
                st_d.vld = vld_i;
                for (int k = 0; k < N; k++) begin
                    st_d.val[k] = vld_i ? d_i[k] : st_q.val[k];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q.vld <= 1'b0;
                    for (int k = 0; k < N; k++) begin
                        st_q.val[k] <= '0;
                    end
                end else begin
                    st_q <= st_d;
                end
            end

            assign vld_o = st_q.vld;
            assign d_o   = st_q.val;
        end else begin : g_wire
            assign vld_o = vld_i;
            assign d_o   = d_i;
        end
    endgenerate
endmodule

// File: rtl/dct8_odd_terms.sv
// Shared shift-add terms of one difference operand. The odd weights come from these:
// A=63 -> m63, C=53 -> t36+t17, D=36 -> t36, F=12 -> t12. The x4 shift feeds both t36 and t12.
module dct8_odd_terms
    import dct8_pkg::*;
(
    input  acc_t w,
    output acc_t m63,
    output acc_t t36,
    output acc_t t17,
    output acc_t t12
);
    acc_t sh2;

    always_comb begin
        sh2 = w <<< 2;
        m63 = (w <<< 6) - w;
        t36 = (w <<< 5) + sh2;
        t17 = (w <<< 4) + w;
        t12 = (w <<< 3) + sh2;
    end
endmodule

// File: rtl/dct8_shiftadd.sv
module dct8_shiftadd
    import dct8_pkg::*;
#(
    parameter bit PIPELINED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_samples,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_coefs
);
    localparam int HALF = LANES / 2;
    localparam int N2   = HALF + 4 * HALF;   // even P,Q,U,V + four terms per difference
    localparam int N3   = 8 + 4 * HALF;      // even partials + A,C,D,F per difference
    localparam int N4   = 16;

    logic v1, v2, v3, v4, v5;
    acc_t x    [LANES];
    acc_t r1_d [LANES], r1_q [LANES];
    acc_t t2   [4*HALF];
    acc_t r2_d [N2], r2_q [N2];
    acc_t r3_d [N3], r3_q [N3];
    acc_t r4_d [N4], r4_q [N4];
    acc_t r5_d [LANES], r5_q [LANES];
    acc_t r6_d [LANES], r6_q [LANES];

    // level 1: mirror-pair butterfly
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            x[k] = acc_t'($signed(in_samples[k*DATA_W +: DATA_W]));
        end
        for (int i = 0; i < HALF; i++) begin
            r1_d[i]        = x[i] + x[LANES-1-i];
            r1_d[HALF + i] = x[i] - x[LANES-1-i];
        end
    end

    dct8_stage #(.N(LANES), .PIPE(PIPELINED)) u_s1 (
        .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .d_i(r1_d), .vld_o(v1), .d_o(r1_q));

    // level 2: even butterfly, shared odd terms
    generate
        for (genvar g = 0; g < HALF; g++) begin : g_terms
            dct8_odd_terms u_terms (
                .w  (r1_q[HALF + g]),
                .m63(t2[4*g]),
                .t36(t2[4*g + 1]),
                .t17(t2[4*g + 2]),
                .t12(t2[4*g + 3]));
        end
    endgenerate

    always_comb begin
        r2_d[0] = r1_q[0] + r1_q[3];   // P
        r2_d[1] = r1_q[1] + r1_q[2];   // Q
        r2_d[2] = r1_q[0] - r1_q[3];   // U
        r2_d[3] = r1_q[1] - r1_q[2];   // V
        for (int k = 0; k < 4*HALF; k++) begin
            r2_d[HALF + k] = t2[k];
        end
    end

    dct8_stage #(.N(N2), .PIPE(PIPELINED)) u_s2 (
        .clk(clk), .rst_n(rst_n), .vld_i(v1), .d_i(r2_d), .vld_o(v2), .d_o(r2_q));

    // level 3: P+/-Q, first rotation partials, odd weights completed
    always_comb begin
        r3_d[0] = r2_q[0] + r2_q[1];
        r3_d[1] = r2_q[0] - r2_q[1];
        r3_d[2] = (r2_q[2] <<< 6) - (r2_q[2] <<< 2);
        r3_d[3] = (r2_q[2] <<< 4) + (r2_q[2] <<< 3);
        r3_d[4] = r2_q[2];
        r3_d[5] = (r2_q[3] <<< 6) - (r2_q[3] <<< 2);
        r3_d[6] = (r2_q[3] <<< 4) + (r2_q[3] <<< 3);
        r3_d[7] = r2_q[3];
        for (int g = 0; g < HALF; g++) begin
            r3_d[8 + 4*g]     = r2_q[HALF + 4*g];                          // A
            r3_d[8 + 4*g + 1] = r2_q[HALF + 4*g + 1] + r2_q[HALF + 4*g + 2]; // C
            r3_d[8 + 4*g + 2] = r2_q[HALF + 4*g + 1];                      // D
            r3_d[8 + 4*g + 3] = r2_q[HALF + 4*g + 3];                      // F
        end
    end

    dct8_stage #(.N(N3), .PIPE(PIPELINED)) u_s3 (
        .clk(clk), .rst_n(rst_n), .vld_i(v2), .d_i(r3_d), .vld_o(v3), .d_o(r3_q));

    // level 4: scale partials, B = 64-4-1 finished, odd pair products
    function automatic acc_t wa(input int g); return r3_q[8 + 4*g];     endfunction
    function automatic acc_t wc(input int g); return r3_q[8 + 4*g + 1]; endfunction
    function automatic acc_t wd(input int g); return r3_q[8 + 4*g + 2]; endfunction
    function automatic acc_t wf(input int g); return r3_q[8 + 4*g + 3]; endfunction

    always_comb begin
        r4_d[0]  = (r3_q[0] <<< 5) + (r3_q[0] <<< 3);
        r4_d[1]  = (r3_q[0] <<< 2) + r3_q[0];
        r4_d[2]  = (r3_q[1] <<< 5) + (r3_q[1] <<< 3);
        r4_d[3]  = (r3_q[1] <<< 2) + r3_q[1];
        r4_d[4]  = r3_q[2] - r3_q[4];   // B*U
        r4_d[5]  = r3_q[3];             // E*U
        r4_d[6]  = r3_q[5] - r3_q[7];   // B*V
        r4_d[7]  = r3_q[6];             // E*V
        r4_d[8]  = wa(0) + wf(3);
        r4_d[9]  = wc(1) + wd(2);
        r4_d[10] = wf(0) - wa(3);
        r4_d[11] = wc(2) - wd(1);
        r4_d[12] = wc(0) - wd(3);
        r4_d[13] = wf(1) + wa(2);
        r4_d[14] = wd(0) + wc(3);
        r4_d[15] = wf(2) - wa(1);
    end

    dct8_stage #(.N(N4), .PIPE(PIPELINED)) u_s4 (
        .clk(clk), .rst_n(rst_n), .vld_i(v3), .d_i(r4_d), .vld_o(v4), .d_o(r4_q));

    // level 5: final sums in coefficient order
    always_comb begin
        r5_d[0] = r4_q[0] + r4_q[1];
        r5_d[4] = r4_q[2] + r4_q[3];
        r5_d[2] = r4_q[4] + r4_q[7];
        r5_d[6] = r4_q[5] - r4_q[6];
        r5_d[1] = r4_q[8] + r4_q[9];
        r5_d[7] = r4_q[10] + r4_q[11];
        r5_d[3] = r4_q[12] - r4_q[13];
        r5_d[5] = r4_q[14] + r4_q[15];
    end

    dct8_stage #(.N(LANES), .PIPE(PIPELINED)) u_s5 (
        .clk(clk), .rst_n(rst_n), .vld_i(v4), .d_i(r5_d), .vld_o(v5), .d_o(r5_q));

    // level 6: single truncation, always registered
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            r6_d[k] = r5_q[k] >>> FRAC_W;
        end
    end

    dct8_stage #(.N(LANES), .PIPE(1'b1)) u_s6 (
        .clk(clk), .rst_n(rst_n), .vld_i(v5), .d_i(r6_d), .vld_o(out_valid), .d_o(r6_q));

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            out_coefs[k*DATA_W +: DATA_W] = r6_q[k][DATA_W-1:0];
        end
    end
endmodule

// File: rtl/dct8_shiftadd_chk.sv
module dct8_shiftadd_chk #(
    parameter bit PIPELINED = 1'b1,
    parameter int BW        = 160
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [BW-1:0] in_samples,
    input logic          out_valid,
    input logic [BW-1:0] out_coefs
);
    localparam int LAT = PIPELINED ? 6 : 1;

    logic [LAT:0] vsr, zsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsr <= '0;
            zsr <= '0;
        end else begin
            vsr <= {vsr[LAT-1:0], in_valid};
            zsr <= {zsr[LAT-1:0], in_valid && (in_samples == '0)};
        end
    end

    // R5 R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsr[LAT-1]);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_coefs == '0));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_coefs));

    // R10
    zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zsr[LAT-1]) |-> out_coefs == '0);
endmodule

bind dct8_shiftadd dct8_shiftadd_chk #(.PIPELINED(PIPELINED), .BW(dct8_pkg::BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .out_valid(out_valid), .out_coefs(out_coefs));

// File: tb/test_dct8_shiftadd.sv
module test_dct8_shiftadd;
    localparam int NV = 8;
    localparam int BW = 160;

    // samples in LSB units (1 LSB = 2^-7)
    localparam int VEC [NV][8] = '{
        '{128, 128, 128, 128, 128, 128, 128, 128},
        '{0, 128, 256, 384, 512, 640, 768, 896},
        '{-1, 0, 0, 0, 0, 0, 0, 0},
        '{512, -512, 512, -512, 512, -512, 512, -512},
        '{1000, -300, 77, 0, -5, 2047, -4096, 333},
        '{999, 999, -999, 5, 6, 7, 8, 9},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{-2000, 1500, -7, 640, 12, -900, 4095, -1}
    };
    localparam bit VV [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [BW-1:0] in_samples = '0;
    logic p_valid, c_valid;
    logic [BW-1:0] p_coefs, c_coefs;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [BW-1:0] exp_v [NV];

    always #10 clk = ~clk;

    dct8_shiftadd #(.PIPELINED(1'b1)) i_dct8_shiftadd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(p_valid), .out_coefs(p_coefs));

    dct8_shiftadd #(.PIPELINED(1'b0)) i_dct8_shiftadd_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(c_valid), .out_coefs(c_coefs));

    function automatic logic [BW-1:0] pack(input int v [8]);
        logic [BW-1:0] r;
        for (int k = 0; k < 8; k++) begin
            r[k*20 +: 20] = v[k][19:0];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] ref_dct(input int v [8]);
        longint s [4], d [4], z [8];
        longint p, q, u, w;
        logic [BW-1:0] r;
        for (int i = 0; i < 4; i++) begin
            s[i] = longint'(v[i]) + longint'(v[7-i]);
            d[i] = longint'(v[i]) - longint'(v[7-i]);
        end
        p = s[0] + s[3]; q = s[1] + s[2];
        u = s[0] - s[3]; w = s[1] - s[2];
        z[0] = (45 * (p + q)) >>> 7;
        z[4] = (45 * (p - q)) >>> 7;
        z[2] = (59 * u + 24 * w) >>> 7;
        z[6] = (24 * u - 59 * w) >>> 7;
        z[1] = (63*d[0] + 53*d[1] + 36*d[2] + 12*d[3]) >>> 7;
        z[3] = (53*d[0] - 12*d[1] - 63*d[2] - 36*d[3]) >>> 7;
        z[5] = (36*d[0] - 63*d[1] + 12*d[2] + 53*d[3]) >>> 7;
        z[7] = (12*d[0] - 36*d[1] + 53*d[2] - 63*d[3]) >>> 7;
        for (int k = 0; k < 8; k++) begin
            r[k*20 +: 20] = z[k][19:0];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one isolated vector through both builds
    task automatic run_one(input logic [BW-1:0] v, input logic [BW-1:0] expv, input string req);
        @(negedge clk);
        in_samples = v;
        in_valid = 1'b1;
        @(negedge clk);
        check_bit({req, " comb out_valid R6"}, c_valid, 1'b1);
        check({req, " comb coefs"}, c_coefs, expv);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check_bit({req, " pipe out_valid R5"}, p_valid, 1'b1);
        check({req, " pipe coefs"}, p_coefs, expv);
        @(negedge clk);
        check_bit({req, " pipe single beat R5"}, p_valid, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [BW-1:0] last_c, last_p;
        for (int j = 0; j < NV; j++) exp_v[j] = ref_dct(VEC[j]);

        // R8 reset state
        repeat (3) @(negedge clk);
        check_bit("R8 reset pipe out_valid", p_valid, 1'b0);
        check_bit("R8 reset comb out_valid", c_valid, 1'b0);
        check("R8 reset pipe coefs", p_coefs, '0);
        check("R8 reset comb coefs", c_coefs, '0);
        rst_n = 1'b1;

        // streamed table, one vector per clock (R7), with a gap (R9)
        last_c = '0;
        last_p = '0;
        for (int t = 0; t < NV + 7; t++) begin
            @(negedge clk);
            if (t >= 1 && t - 1 < NV) begin
                check_bit("R6 R7 R9 comb out_valid", c_valid, VV[t-1]);
                if (VV[t-1]) begin
                    check("R1 R2 R3 R4 R7 comb coefs", c_coefs, exp_v[t-1]);
                    last_c = exp_v[t-1];
                end else begin
                    check("R9 comb hold", c_coefs, last_c);
                end
            end
            if (t >= 6 && t - 6 < NV) begin
                check_bit("R5 R7 R9 pipe out_valid", p_valid, VV[t-6]);
                if (VV[t-6]) begin
                    check("R1 R2 R3 R4 R7 pipe coefs", p_coefs, exp_v[t-6]);
                    last_p = exp_v[t-6];
                end else begin
                    check("R9 pipe hold", p_coefs, last_p);
                end
            end
            if (t < NV) begin
                in_samples = pack(VEC[t]);
                in_valid = VV[t];
            end else begin
                in_samples = '0;
                in_valid = 1'b0;
            end
        end

        // R4 single negative LSB: every coefficient floors to -1
        run_one(pack('{-1, 0, 0, 0, 0, 0, 0, 0}), {8{20'hFFFFF}}, "R4 neg lsb");
        // R4 single positive LSB: every coefficient floors to 0
        run_one(pack('{1, 0, 0, 0, 0, 0, 0, 0}), '0, "R4 pos lsb");
        // R1 constant 1.0 gives coefficient 0 = 360 LSB (2.8125), rest zero
        run_one(pack('{128, 128, 128, 128, 128, 128, 128, 128}), {140'd0, 20'd360}, "R1 dc");
        // R10 zero vector
        run_one('0, '0, "R10 zero");

        // R8 reset with vectors in flight
        @(negedge clk);
        in_samples = pack(VEC[7]);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 midflight pipe coefs", p_coefs, '0);
        check("R8 midflight comb coefs", c_coefs, '0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check_bit("R8 no stale pipe valid", p_valid, 1'b0);
            check_bit("R8 no stale comb valid", c_valid, 1'b0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule